// File: doc/BRIEF.md
# Wake-up and External Interrupt Controller

This block collects event lines and turns them into per-line interrupt requests and a single wake-up request for the power controller. Sixteen external lines come from GPIO pins; the pins are grouped in banks, and line n can watch pin n of any one bank, chosen per line by a selector field. Further internal event lines come from peripherals in the same clock domain. Every line latches its events into a pending flag, which software clears by writing 1.

External pins are synchronized, and the selected pin of each line is compared with its previous value to detect rising or falling edges, each edge kind enabled separately. Internal lines set their pending flag on a one-cycle pulse. Pending flags are qualified by an interrupt mask to form the interrupt vector and by a wake-up mask to form the wake-up request. Only the external lines and a parameter-chosen subset of internal lines can ever interrupt; the remaining internal lines can only wake the system. A per-line security attribute protects configuration and clearing from non-secure bus masters, and hides secure lines on non-secure reads.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset every register reads 0 (all lines non-secure, all lines on bank 0, no edge enabled, all masks clear, nothing pending), irq_o is 0 and wake_o is 0.
- R2: Register map by word address: 0 rising-edge enables (bits 15:0), 1 falling-edge enables (bits 15:0), 2 interrupt mask, 3 wake-up mask, 4 pending, 5 security, 6 bank selectors. Lines 0..15 are external, lines 16 upward are internal. An enabled edge on an external pin sets the line's pending bit, visible after the third rising clock edge after the pin changes and not after the second; a disabled edge kind sets nothing.
- R3: External line n follows pin n of the bank chosen by bits [2n+1:2n] of register 6 (pin index bank*16+n on gpio_i); pins of other banks have no effect on the line.
- R4: Changing a line's bank selector never creates an event, even when the old and new pins differ in level.
- R5: An internal event pulse sets its pending bit at the next clock edge. Only internal lines whose IRQ_CAP bit is 1 (default: lines 16 and 17) can drive irq_o; for the others the interrupt mask bit reads 0 and irq_o stays 0.
- R6: irq_o bit n is 1 exactly when line n is pending and its interrupt mask bit is 1.
- R7: wake_o is 1 exactly when some line is pending with its wake-up mask bit set, including wake-only internal lines.
- R8: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged.
- R9: If an event and a clearing write hit the same line in one cycle, the pending bit stays set.
- R10: Non-secure writes (bus_sec_i = 0) do not change the enables, masks, bank selector or pending bit of a line whose security bit is 1.
- R11: Non-secure reads return 0 for secure lines' bits in all registers except register 5; register 5 is readable by all but writable only by secure writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gpio_i | input | NUM_BANKS*16 | Asynchronous GPIO pins, bank b pin n at index b*16+n |
| int_evt_i | input | NUM_INT | Internal event pulses, synchronous to clk_i |
| bus_en_i | input | 1 | Bus access strobe for a write |
| bus_wr_i | input | 1 | Write qualifier |
| bus_sec_i | input | 1 | 1 when the access is secure |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 16+NUM_INT | Per-line interrupt requests |
| wake_o | output | 1 | Wake-up request to the power controller |

## Verification
Edges are tried as rising and falling transitions on lines with one, both or neither edge kind enabled, which separates the two enable bits and shows the synchronizer latency. Pins of unselected banks are toggled, and a bank switch between pins at different levels is made, to tell selection apart from a spurious event. Internal pulses on interrupt-capable and wake-only lines, with and without wake-up mask, separate the irq_o and wake_o paths, and the same bus sequences issued as secure and as non-secure show the effect of the security bits on writes, clears and reads.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    localparam int EXT_LINES = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RISE  = 3'd0,
        REG_FALL  = 3'd1,
        REG_IMASK = 3'd2,
        REG_WMASK = 3'd3,
        REG_PEND  = 3'd4,
        REG_SEC   = 3'd5,
        REG_BSEL  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge
    import wkup_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SELW      = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_BANKS*EXT_LINES-1:0] pins_i,
    input  logic [EXT_LINES*SELW-1:0]     bsel_q_i,
    input  logic [EXT_LINES*SELW-1:0]     bsel_d_i,
    output logic [EXT_LINES-1:0]          rise_o,
    output logic [EXT_LINES-1:0]          fall_o
);
    logic [EXT_LINES-1:0] cur, nxt;
    logic [EXT_LINES-1:0] prev_d, prev_q;

    for (genvar n = 0; n < EXT_LINES; n++) begin : g_line
        always_comb begin
            cur[n] = 1'b0;
            nxt[n] = 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(bsel_q_i[n*SELW +: SELW]) == b) cur[n] = pins_i[b*EXT_LINES + n];
                if (int'(bsel_d_i[n*SELW +: SELW]) == b) nxt[n] = pins_i[b*EXT_LINES + n];
            end
        end
    end

    // previous value follows the pin that will be selected after this edge
    always_comb begin
        prev_d = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign rise_o = cur & ~prev_q;
    assign fall_o = ~cur & prev_q;
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
#(
    parameter int                NUM_INT   = 8,
    parameter int                NUM_BANKS = 4,
    parameter int                SELW      = 2,
    parameter logic [NUM_INT-1:0] IRQ_CAP  = 'h3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          bus_en_i,
    input  logic                          bus_wr_i,
    input  logic                          bus_sec_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    input  logic [EXT_LINES-1:0]          ext_rise_i,
    input  logic [EXT_LINES-1:0]          ext_fall_i,
    input  logic [NUM_INT-1:0]            int_evt_i,
    output logic [EXT_LINES+NUM_INT-1:0]  pend_o,
    output logic [EXT_LINES+NUM_INT-1:0]  imask_o,
    output logic [EXT_LINES+NUM_INT-1:0]  wmask_o,
    output logic [EXT_LINES+NUM_INT-1:0]  sec_o,
    output logic [EXT_LINES*SELW-1:0]     bsel_q_o,
    output logic [EXT_LINES*SELW-1:0]     bsel_d_o
);
    localparam int NL = EXT_LINES + NUM_INT;
    localparam int BW = EXT_LINES * SELW;
    localparam logic [NL-1:0] CAP_ALL = {IRQ_CAP, {EXT_LINES{1'b1}}};

    typedef struct packed {
        logic [EXT_LINES-1:0] rise;
        logic [EXT_LINES-1:0] fall;
        logic [NL-1:0]        imask;
        logic [NL-1:0]        wmask;
        logic [NL-1:0]        pend;
        logic [NL-1:0]        sec;
        logic [BW-1:0]        bsel;
    } regs_t;

    regs_t st_d, st_q;

    logic          wr;
    logic [NL-1:0] lmask;
    logic [NL-1:0] wd;
    logic [NL-1:0] clr;
    logic [NL-1:0] evt;

    always_comb begin
        wr    = bus_en_i & bus_wr_i;
        lmask = bus_sec_i ? '1 : ~st_q.sec;
        wd    = bus_wdata_i[NL-1:0];
        evt   = {int_evt_i, (ext_rise_i & st_q.rise) | (ext_fall_i & st_q.fall)};
        clr   = '0;
        st_d  = st_q;
        if (wr) begin
            case (reg_addr_e'(bus_addr_i))
                REG_RISE:  st_d.rise  = (st_q.rise & ~lmask[EXT_LINES-1:0])
                                      | (wd[EXT_LINES-1:0] & lmask[EXT_LINES-1:0]);
                REG_FALL:  st_d.fall  = (st_q.fall & ~lmask[EXT_LINES-1:0])
                                      | (wd[EXT_LINES-1:0] & lmask[EXT_LINES-1:0]);
                REG_IMASK: st_d.imask = ((st_q.imask & ~lmask) | (wd & lmask)) & CAP_ALL;
                REG_WMASK: st_d.wmask = (st_q.wmask & ~lmask) | (wd & lmask);
                REG_PEND:  clr        = wd & lmask;
                REG_SEC:   if (bus_sec_i) st_d.sec = wd;
                REG_BSEL: begin
                    for (int n = 0; n < EXT_LINES; n++) begin
                        if (lmask[n] && (int'(bus_wdata_i[n*SELW +: SELW]) < NUM_BANKS))
                            st_d.bsel[n*SELW +: SELW] = bus_wdata_i[n*SELW +: SELW];
                    end
                end
                default: ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // read path: secure lines hidden from non-secure masters
    logic [NL-1:0] rmask;
    logic [BW-1:0] bmask;

    always_comb begin
        rmask       = bus_sec_i ? '1 : ~st_q.sec;
        bmask       = '0;
        for (int n = 0; n < EXT_LINES; n++) bmask[n*SELW +: SELW] = {SELW{rmask[n]}};
        bus_rdata_o = '0;
        case (reg_addr_e'(bus_addr_i))
            REG_RISE:  bus_rdata_o[EXT_LINES-1:0] = st_q.rise & rmask[EXT_LINES-1:0];
            REG_FALL:  bus_rdata_o[EXT_LINES-1:0] = st_q.fall & rmask[EXT_LINES-1:0];
            REG_IMASK: bus_rdata_o[NL-1:0]        = st_q.imask & rmask;
            REG_WMASK: bus_rdata_o[NL-1:0]        = st_q.wmask & rmask;
            REG_PEND:  bus_rdata_o[NL-1:0]        = st_q.pend & rmask;
            REG_SEC:   bus_rdata_o[NL-1:0]        = st_q.sec;
            REG_BSEL:  bus_rdata_o[BW-1:0]        = st_q.bsel & bmask;
            default:   bus_rdata_o                = '0;
        endcase
    end

    assign pend_o   = st_q.pend;
    assign imask_o  = st_q.imask;
    assign wmask_o  = st_q.wmask;
    assign sec_o    = st_q.sec;
    assign bsel_q_o = st_q.bsel;
    assign bsel_d_o = st_d.bsel;
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int                 NUM_BANKS = 4,
    parameter int                 NUM_INT   = 8,
    parameter logic [NUM_INT-1:0] IRQ_CAP   = 'h3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_BANKS*16-1:0]       gpio_i,
    input  logic [NUM_INT-1:0]            int_evt_i,
    input  logic                          bus_en_i,
    input  logic                          bus_wr_i,
    input  logic                          bus_sec_i,
    input  logic [2:0]                    bus_addr_i,
    input  logic [31:0]                   bus_wdata_i,
    output logic [31:0]                   bus_rdata_o,
    output logic [16+NUM_INT-1:0]         irq_o,
    output logic                          wake_o
);
    localparam int NL   = EXT_LINES + NUM_INT;
    localparam int SELW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int NP   = NUM_BANKS * EXT_LINES;

    logic [NP-1:0]             pins_s;
    logic [EXT_LINES-1:0]      rise_w, fall_w;
    logic [NL-1:0]             pend_w, imask_w, wmask_w, sec_w;
    logic [EXT_LINES*SELW-1:0] bsel_q_w, bsel_d_w;

    wkup_sync #(.W(NP)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (gpio_i),
        .q_o    (pins_s)
    );

    wkup_edge #(.NUM_BANKS(NUM_BANKS), .SELW(SELW)) u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pins_i   (pins_s),
        .bsel_q_i (bsel_q_w),
        .bsel_d_i (bsel_d_w),
        .rise_o   (rise_w),
        .fall_o   (fall_w)
    );

    wkup_regs #(
        .NUM_INT(NUM_INT), .NUM_BANKS(NUM_BANKS), .SELW(SELW), .IRQ_CAP(IRQ_CAP)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_en_i    (bus_en_i),
        .bus_wr_i    (bus_wr_i),
        .bus_sec_i   (bus_sec_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ext_rise_i  (rise_w),
        .ext_fall_i  (fall_w),
        .int_evt_i   (int_evt_i),
        .pend_o      (pend_w),
        .imask_o     (imask_w),
        .wmask_o     (wmask_w),
        .sec_o       (sec_w),
        .bsel_q_o    (bsel_q_w),
        .bsel_d_o    (bsel_d_w)
    );

    always_comb begin
        irq_o  = pend_w & imask_w;
        wake_o = |(pend_w & wmask_w);
    end
endmodule

// File: rtl/wkup_ctrl_chk.sv
module wkup_ctrl_chk #(
    parameter int NUM_INT = 8
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  bus_en_i,
    input logic                  bus_wr_i,
    input logic                  bus_sec_i,
    input logic [2:0]            bus_addr_i,
    input logic [NUM_INT-1:0]    int_evt_i,
    input logic [16+NUM_INT-1:0] pend_vec,
    input logic [16+NUM_INT-1:0] sec_vec
);
    // R1: security attribute is clear when reset is released
    a_r1_sec_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (sec_vec == '0));

    // R8: a pending bit only falls after a write to the pending register
    a_r8_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_en_i && bus_wr_i && bus_addr_i == 3'd4) |=> (($past(pend_vec) & ~pend_vec) == '0));

    // R10: non-secure clears leave secure pending bits alone
    a_r10_ns_clear_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_en_i && bus_wr_i && !bus_sec_i && bus_addr_i == 3'd4)
        |=> ((($past(pend_vec) & $past(sec_vec)) & ~pend_vec) == '0));

    // R5 / R9: an internal pulse is always pending one cycle later
    a_r5_int_event_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_evt_i != '0) |=> ((pend_vec[16+NUM_INT-1:16] & $past(int_evt_i)) == $past(int_evt_i)));

    // R11: security register ignores non-secure writes
    a_r11_sec_reg_ns_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_en_i && bus_wr_i && !bus_sec_i && bus_addr_i == 3'd5) |=> $stable(sec_vec));
endmodule

bind wkup_ctrl wkup_ctrl_chk #(.NUM_INT(NUM_INT)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_en_i   (bus_en_i),
    .bus_wr_i   (bus_wr_i),
    .bus_sec_i  (bus_sec_i),
    .bus_addr_i (bus_addr_i),
    .int_evt_i  (int_evt_i),
    .pend_vec   (pend_w),
    .sec_vec    (sec_w)
);

// File: tb/wkup_ctrl_tb_top.sv
module wkup_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int NI = 8;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [NB*16-1:0] gpio_i = '0;
    logic [NI-1:0] int_evt_i = '0;
    logic          bus_en_i = 1'b0;
    logic          bus_wr_i = 1'b0;
    logic          bus_sec_i = 1'b1;
    logic [2:0]    bus_addr_i = '0;
    logic [31:0]   bus_wdata_i = '0;
    logic [31:0]   bus_rdata_o;
    logic [16+NI-1:0] irq_o;
    logic          wake_o;

    wkup_ctrl #(.NUM_BANKS(NB), .NUM_INT(NI), .IRQ_CAP(8'h03)) dut_i (.*);

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    typedef struct {
        string       req;
        int          kind;   // 0 read data, 1 irq vector, 2 wake
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata_o;
                    1:       act = 32'(irq_o);
                    default: act = {31'b0, wake_o};
                endcase
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(string req, int kind, logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic rd(string req, logic [2:0] a, logic s, logic [31:0] exp);
        bus_addr_i = a;
        bus_sec_i  = s;
        push_exp(req, 0, exp);
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, logic s);
        @(negedge clk_i);
        bus_en_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_sec_i = s;
        @(negedge clk_i);
        bus_en_i = 0; bus_wr_i = 0; bus_sec_i = 1;
    endtask

    task automatic pulse(int idx);
        @(negedge clk_i);
        int_evt_i[idx] = 1'b1;
        @(negedge clk_i);
        int_evt_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_ni = 1'b1;
        ticks(1);
        // R1: reset state
        for (int a = 0; a < 7; a++) rd("R1 reset register", 3'(a), 1'b1, 32'h0);
        push_exp("R1 reset irq", 1, 32'h0);
        push_exp("R1 reset wake", 2, 32'h0);

        // R2: rising edge on line 0, latency
        wr(3'd0, 32'h1, 1);
        wr(3'd2, 32'h1, 1);
        ticks(1);
        gpio_i[0] = 1'b1;
        ticks(2);
        rd("R2 not pending after two edges", 3'd4, 1, 32'h0);
        ticks(1);
        rd("R2 pending after third edge", 3'd4, 1, 32'h1);
        push_exp("R6 irq follows pending", 1, 32'h1);
        wr(3'd2, 32'h0, 1);
        push_exp("R6 masked line gives no irq", 1, 32'h0);
        wr(3'd4, 32'h1, 1);
        rd("R8 write one clears", 3'd4, 1, 32'h0);
        gpio_i[0] = 1'b0;
        ticks(4);
        rd("R2 falling edge not enabled", 3'd4, 1, 32'h0);
        wr(3'd1, 32'h2, 1);
        gpio_i[1] = 1'b1;
        ticks(4);
        rd("R2 rising edge not enabled on line 1", 3'd4, 1, 32'h0);
        gpio_i[1] = 1'b0;
        ticks(4);
        rd("R2 falling edge on line 1", 3'd4, 1, 32'h2);
        wr(3'd4, 32'h2, 1);

        // R3: bank selection for line 2
        wr(3'd6, 32'h20, 1);
        wr(3'd0, 32'h5, 1);
        gpio_i[2] = 1'b1;
        ticks(4);
        rd("R3 unselected bank ignored", 3'd4, 1, 32'h0);
        gpio_i[2] = 1'b0;
        gpio_i[34] = 1'b1;
        ticks(4);
        rd("R3 selected bank pin", 3'd4, 1, 32'h4);
        wr(3'd4, 32'h4, 1);

        // R4: switch bank between pins at different levels
        wr(3'd1, 32'h6, 1);
        wr(3'd6, 32'h30, 1);
        ticks(4);
        rd("R4 no event on bank switch", 3'd4, 1, 32'h0);
        rd("R3 selector readback", 3'd6, 1, 32'h30);
        gpio_i[50] = 1'b1;
        ticks(4);
        rd("R3 new bank pin works", 3'd4, 1, 32'h4);
        wr(3'd4, 32'h4, 1);

        // R5 / R7: internal events
        wr(3'd2, 32'h50001, 1);
        rd("R5 wake-only imask bit reads 0", 3'd2, 1, 32'h10001);
        wr(3'd3, 32'h50000, 1);
        push_exp("R7 no wake idle", 2, 32'h0);
        pulse(0);
        rd("R5 internal pulse pends", 3'd4, 1, 32'h10000);
        push_exp("R5 capable line irq", 1, 32'h10000);
        push_exp("R7 wake from line 16", 2, 32'h1);
        pulse(2);
        rd("R5 wake-only pends", 3'd4, 1, 32'h50000);
        push_exp("R5 wake-only line no irq", 1, 32'h10000);
        wr(3'd4, 32'h0, 1);
        rd("R8 write zero no effect", 3'd4, 1, 32'h50000);
        wr(3'd4, 32'h10000, 1);
        push_exp("R7 wake from wake-only line", 2, 32'h1);
        wr(3'd4, 32'h40000, 1);
        push_exp("R7 wake drops", 2, 32'h0);
        pulse(3);
        push_exp("R7 unmasked line no wake", 2, 32'h0);
        rd("R5 line 19 pends", 3'd4, 1, 32'h80000);
        wr(3'd4, 32'h80000, 1);

        // R9: event and clear in the same cycle
        @(negedge clk_i);
        int_evt_i[0] = 1'b1;
        bus_en_i = 1; bus_wr_i = 1; bus_addr_i = 3'd4; bus_wdata_i = 32'h10000; bus_sec_i = 1;
        @(negedge clk_i);
        int_evt_i = '0; bus_en_i = 0; bus_wr_i = 0;
        rd("R9 event wins over clear", 3'd4, 1, 32'h10000);
        wr(3'd4, 32'h10000, 1);

        // R10 / R11: security
        wr(3'd5, 32'h1, 1);
        gpio_i[0] = 1'b1;
        ticks(3);
        rd("R10 secure line pends", 3'd4, 1, 32'h1);
        wr(3'd4, 32'h1, 0);
        rd("R10 non-secure clear ignored", 3'd4, 1, 32'h1);
        rd("R11 non-secure read hides pending", 3'd4, 0, 32'h0);
        wr(3'd0, 32'h0, 0);
        rd("R10 non-secure enable write partial", 3'd0, 1, 32'h1);
        rd("R11 non-secure read hides enable", 3'd0, 0, 32'h0);
        wr(3'd5, 32'h0, 0);
        rd("R11 security register locked", 3'd5, 0, 32'h1);
        wr(3'd6, 32'h33, 0);
        rd("R10 selector of secure line kept", 3'd6, 1, 32'h30);
        wr(3'd4, 32'h1, 1);
        rd("R8 secure clear works", 3'd4, 1, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule